// File: doc/BRIEF.md
# I2C Controller Interrupt and FIFO-Status Unit

This block is the register-side status logic of an I2C master controller. It collects event pulses from the bus engine (start and stop conditions, bus activity, general call, transmit abort, received bytes, transmitted bytes) and CPU accesses to the byte-queue address, and turns them into a raw interrupt word, a per-source enable word, a masked pending word and one combined interrupt line. It tracks the fill level of a 16-entry transmit queue and a 16-entry receive queue, compares both against programmable thresholds, and reports a status word with the queue and bus conditions. The data storage of the queues lives outside the block; reads of the queue address return zero here.

Error and event flags are sticky and are cleared by *reading* a clear address: one address per source plus one address that clears them all. A clear read returns, in bit 0, whether the flag it targets was set at the moment of the read. The threshold flags are not stored; they follow the queue levels. A transmit abort is handled by a two-state machine: `TXA_RUN` moves to `TXA_HOLD` on an abort pulse; `TXA_HOLD` returns to `TXA_RUN` on a read of the abort clear address or of the global clear address when no new abort arrives in the same cycle. While in `TXA_HOLD` the transmit queue is held empty, CPU pushes are discarded and `tx_flush` is high.

CPU register map (byte addresses): 0x00 queue (write pushes a TX byte, read pops an RX byte), 0x04 pending, 0x08 enable, 0x0C raw, 0x10 RX threshold, 0x14 TX threshold, 0x18 status, 0x1C TX level, 0x20 RX level, 0x24 abort cause, 0x40 global clear, 0x44 clear RX underflow, 0x48 clear RX overflow, 0x4C clear TX overflow, 0x50 clear abort, 0x54 clear activity, 0x58 clear stop, 0x5C clear start, 0x60 clear general call.

Top module: `i2cs_unit`

## Requirements
- R1: After reset the enable word reads 0x8FF, the status word reads 0x06 (with `eng_ctrl_active` and `eng_bus_busy` low), the TX threshold reads 0, the RX threshold reads 1, the raw word reads 0x010 and `cpu_rdata` is 0.
- R2: The raw word places its flags at bit 11 general call, bit 10 start seen, bit 9 stop seen, bit 8 activity, bit 6 transmit abort, bit 4 TX at-or-below threshold, bit 3 TX overflow, bit 2 RX at-or-above threshold, bit 1 RX overflow, bit 0 RX underflow; bits 5, 7 and 31:12 read 0.
- R3: The pending word equals the raw word ANDed with the enable word (12 bits, written from `cpu_wdata` at 0x08), and `irq` is high exactly when the pending word is non-zero.
- R4: Raw bit 4 is 1 while the TX level is at or below the TX threshold and drops on its own once the level rises above it.
- R5: Raw bit 2 is 1 while the RX level is at or above the RX threshold and drops on its own once the level falls below it.
- R6: Threshold writes take `cpu_wdata[7:0]`; values 0 to 16 are stored as given and any larger value is stored and read back as 16.
- R7: A queue write while the TX level is 16 sets raw bit 3 and leaves the level at 16; a TX pop from the engine when the level is 0 has no effect.
- R8: A queue read while the RX level is 0 sets raw bit 0; an engine RX push while the RX level is 16 sets raw bit 1 and the byte is not counted. Both judgements use the level at the start of the cycle.
- R9: Reading a per-source clear address clears its flag and returns bit 0 = the flag value before the read; a set event in the same cycle as the clear wins.
- R10: An abort pulse sets raw bit 6 and `tx_flush`, forces the TX level to 0 and ORs `eng_abort_cause` into the abort-cause word; while held, queue writes are discarded without setting bit 3; a read of 0x50 releases the hold and clears the cause word, unless a new abort arrives in that cycle.
- R11: A read of 0x40 clears every sticky flag, the abort hold and the cause word, returns bit 0 = OR of those flags, and leaves raw bits 4 and 2 unchanged.
- R12: While `eng_bus_busy` is high, reads of 0x54 or 0x40 do not clear raw bit 8.
- R13: The status word holds bit 5 `eng_ctrl_active`, bit 4 RX level is 16, bit 3 RX level non-zero, bit 2 TX level is 0, bit 1 TX level below 16, bit 0 `eng_bus_busy`.
- R14: `cpu_rdata` is registered: it shows the value addressed by a read in the cycle after the read strobe (state before that edge) and 0 in the cycle after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 8 | CPU byte address |
| cpu_wdata | input | 12 | CPU write data |
| cpu_rdata | output | 32 | Registered read data |
| eng_start | input | 1 | Start or repeated start seen on the bus |
| eng_stop | input | 1 | Stop seen on the bus |
| eng_activity | input | 1 | Any bus activity |
| eng_gen_call | input | 1 | General call acknowledged |
| eng_abort | input | 1 | Transmit abort pulse |
| eng_abort_cause | input | 17 | Cause bits accompanying an abort pulse |
| eng_tx_pop | input | 1 | Engine consumed one TX byte |
| eng_rx_push | input | 1 | Engine delivered one RX byte |
| eng_ctrl_active | input | 1 | Controller state machine not idle |
| eng_bus_busy | input | 1 | Bus currently busy |
| irq | output | 1 | Combined interrupt |
| tx_flush | output | 1 | Hold the TX queue flushed |

## Verification
The hardest conditions to reach from the ports are the same-cycle collisions: an abort pulse arriving in the very cycle its clear address is read, an event pulse coinciding with the read of its own clear address, and a clear of the activity flag while the bus is still busy. Directed steps line these up one cycle at a time, and a long mixed phase of random strobes over every address, sparse engine pulses and a toggling busy level drives the queues into full, empty and overflow while a behavioural model is compared against `irq`, `tx_flush` and `cpu_rdata` at every clock.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int IRQ_W = 12;

    // raw word bit positions (decoded by software)
    localparam int B_RXUND = 0;
    localparam int B_RXOVR = 1;
    localparam int B_RXTHR = 2;
    localparam int B_TXOVR = 3;
    localparam int B_TXTHR = 4;
    localparam int B_TXABT = 6;
    localparam int B_ACT   = 8;
    localparam int B_STOP  = 9;
    localparam int B_START = 10;
    localparam int B_GCALL = 11;

    localparam logic [IRQ_W-1:0] STICKY_MASK = 12'hF0B;
    localparam logic [IRQ_W-1:0] EN_RST      = 12'h8FF;

    // CPU byte addresses
    localparam logic [7:0] A_QUEUE  = 8'h00;
    localparam logic [7:0] A_PEND   = 8'h04;
    localparam logic [7:0] A_EN     = 8'h08;
    localparam logic [7:0] A_RAW    = 8'h0C;
    localparam logic [7:0] A_RXTHR  = 8'h10;
    localparam logic [7:0] A_TXTHR  = 8'h14;
    localparam logic [7:0] A_STAT   = 8'h18;
    localparam logic [7:0] A_TXLVL  = 8'h1C;
    localparam logic [7:0] A_RXLVL  = 8'h20;
    localparam logic [7:0] A_CAUSE  = 8'h24;
    localparam logic [7:0] A_CLRALL = 8'h40;
    localparam logic [7:0] A_CLRRXU = 8'h44;
    localparam logic [7:0] A_CLRRXO = 8'h48;
    localparam logic [7:0] A_CLRTXO = 8'h4C;
    localparam logic [7:0] A_CLRTXA = 8'h50;
    localparam logic [7:0] A_CLRACT = 8'h54;
    localparam logic [7:0] A_CLRSTP = 8'h58;
    localparam logic [7:0] A_CLRSTA = 8'h5C;
    localparam logic [7:0] A_CLRGC  = 8'h60;

    typedef enum logic {
        TXA_RUN  = 1'b0,
        TXA_HOLD = 1'b1
    } txa_state_e;

endpackage

// File: rtl/i2cs_lvl_cnt.sv
// Occupancy tracker for one byte queue; data storage lives elsewhere.
module i2cs_lvl_cnt #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic [LVL_W-1:0] lvl,
    output logic             full,
    output logic             empty,
    output logic             push_lost
);
    logic [LVL_W-1:0] lvl_q;
    logic             push_ok;
    logic             pop_ok;

    assign full      = (lvl_q == LVL_W'(DEPTH));
    assign empty     = (lvl_q == '0);
    assign push_ok   = push & ~full;
    assign pop_ok    = pop & ~empty;
    assign push_lost = push & full & ~flush;
    assign lvl       = lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (flush) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end
endmodule

// File: rtl/i2cs_thr_flag.sv
// Programmable threshold with clamping and a level-following flag.
module i2cs_thr_flag #(
    parameter int DEPTH       = 16,
    parameter bit AT_OR_ABOVE = 1'b0,
    parameter int RST_THR     = 0,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_val,
    input  logic [LVL_W-1:0] lvl,
    output logic [LVL_W-1:0] thr,
    output logic             flag
);
    logic [LVL_W-1:0] thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= LVL_W'(RST_THR);
        end else if (wr_en) begin
            if (int'(wr_val) > DEPTH) thr_q <= LVL_W'(DEPTH);
            else                      thr_q <= wr_val[LVL_W-1:0];
        end
    end

    assign thr = thr_q;

    generate
        if (AT_OR_ABOVE) begin : g_above
            assign flag = (lvl >= thr_q);
        end else begin : g_below
            assign flag = (lvl <= thr_q);
        end
    endgenerate
endmodule

// File: rtl/i2cs_txabt_fsm.sv
// Transmit-abort latch: holds the TX queue flushed until released.
module i2cs_txabt_fsm
    import i2cs_pkg::*;
#(
    parameter int SRC_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic [SRC_W-1:0] cause,
    input  logic             release_req,
    output logic             hold,
    output logic [SRC_W-1:0] src
);
    txa_state_e       state_q;
    txa_state_e       state_d;
    logic [SRC_W-1:0] src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXA_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXA_RUN:  if (abort) state_d = TXA_HOLD;
            TXA_HOLD: if (release_req && !abort) state_d = TXA_RUN;
            default:  state_d = TXA_RUN;
        endcase
    end

    always_comb begin
        hold = (state_q == TXA_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else if (release_req) begin
            src_q <= abort ? cause : '0;
        end else if (abort) begin
            src_q <= src_q | cause;
        end
    end

    assign src = src_q;
endmodule

// File: rtl/i2cs_unit.sv
module i2cs_unit
    import i2cs_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int SRC_W      = 17,
    parameter int TX_THR_RST = 0,
    parameter int RX_THR_RST = 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [7:0]       cpu_addr,
    input  logic [IRQ_W-1:0] cpu_wdata,
    output logic [31:0]      cpu_rdata,
    input  logic             eng_start,
    input  logic             eng_stop,
    input  logic             eng_activity,
    input  logic             eng_gen_call,
    input  logic             eng_abort,
    input  logic [SRC_W-1:0] eng_abort_cause,
    input  logic             eng_tx_pop,
    input  logic             eng_rx_push,
    input  logic             eng_ctrl_active,
    input  logic             eng_bus_busy,
    output logic             irq,
    output logic             tx_flush
);
    logic             rd_at;
    logic             clr_all;
    logic             release_req;
    logic             hold;
    logic [SRC_W-1:0] cause_q;

    logic [LVL_W-1:0] tx_lvl, rx_lvl, tx_thr, rx_thr;
    logic             tx_full, tx_empty, tx_over;
    logic             rx_full, rx_empty, rx_over, rx_under;
    logic             tx_thr_flag, rx_thr_flag;

    logic [IRQ_W-1:0] set_v, clr_v, sticky_v, raw_v, en_q, pend_v;
    logic [31:0]      rd_val;
    logic [31:0]      rdata_q;

    assign rd_at       = cpu_rd;
    assign clr_all     = cpu_rd && (cpu_addr == A_CLRALL);
    assign release_req = cpu_rd && ((cpu_addr == A_CLRTXA) || (cpu_addr == A_CLRALL));
    assign rx_under    = cpu_rd && (cpu_addr == A_QUEUE) && rx_empty;

    i2cs_txabt_fsm #(.SRC_W(SRC_W)) u_txabt (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (eng_abort),
        .cause      (eng_abort_cause),
        .release_req(release_req),
        .hold       (hold),
        .src        (cause_q)
    );

    i2cs_lvl_cnt #(.DEPTH(DEPTH)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (eng_abort | hold),
        .push     (cpu_wr && (cpu_addr == A_QUEUE)),
        .pop      (eng_tx_pop),
        .lvl      (tx_lvl),
        .full     (tx_full),
        .empty    (tx_empty),
        .push_lost(tx_over)
    );

    i2cs_lvl_cnt #(.DEPTH(DEPTH)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (1'b0),
        .push     (eng_rx_push),
        .pop      (rd_at && (cpu_addr == A_QUEUE)),
        .lvl      (rx_lvl),
        .full     (rx_full),
        .empty    (rx_empty),
        .push_lost(rx_over)
    );

    i2cs_thr_flag #(.DEPTH(DEPTH), .AT_OR_ABOVE(1'b0), .RST_THR(TX_THR_RST)) u_txthr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr && (cpu_addr == A_TXTHR)),
        .wr_val(cpu_wdata[7:0]),
        .lvl   (tx_lvl),
        .thr   (tx_thr),
        .flag  (tx_thr_flag)
    );

    i2cs_thr_flag #(.DEPTH(DEPTH), .AT_OR_ABOVE(1'b1), .RST_THR(RX_THR_RST)) u_rxthr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr && (cpu_addr == A_RXTHR)),
        .wr_val(cpu_wdata[7:0]),
        .lvl   (rx_lvl),
        .thr   (rx_thr),
        .flag  (rx_thr_flag)
    );

    // set and clear requests per raw bit
    always_comb begin
        set_v          = '0;
        set_v[B_RXUND] = rx_under;
        set_v[B_RXOVR] = rx_over;
        set_v[B_TXOVR] = tx_over;
        set_v[B_ACT]   = eng_activity;
        set_v[B_STOP]  = eng_stop;
        set_v[B_START] = eng_start;
        set_v[B_GCALL] = eng_gen_call;

        clr_v          = '0;
        clr_v[B_RXUND] = clr_all || (rd_at && cpu_addr == A_CLRRXU);
        clr_v[B_RXOVR] = clr_all || (rd_at && cpu_addr == A_CLRRXO);
        clr_v[B_TXOVR] = clr_all || (rd_at && cpu_addr == A_CLRTXO);
        clr_v[B_ACT]   = (clr_all || (rd_at && cpu_addr == A_CLRACT)) && !eng_bus_busy;
        clr_v[B_STOP]  = clr_all || (rd_at && cpu_addr == A_CLRSTP);
        clr_v[B_START] = clr_all || (rd_at && cpu_addr == A_CLRSTA);
        clr_v[B_GCALL] = clr_all || (rd_at && cpu_addr == A_CLRGC);
    end

    // sticky flags; positions outside STICKY_MASK stay zero
    generate
        for (genvar b = 0; b < IRQ_W; b++) begin : g_flag
            logic f_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)               f_q <= 1'b0;
                else if (!STICKY_MASK[b]) f_q <= 1'b0;
                else if (set_v[b])        f_q <= 1'b1;
                else if (clr_v[b])        f_q <= 1'b0;
            end
            assign sticky_v[b] = f_q;
        end
    endgenerate

    always_comb begin
        raw_v          = sticky_v;
        raw_v[B_TXABT] = hold;
        raw_v[B_TXTHR] = tx_thr_flag;
        raw_v[B_RXTHR] = rx_thr_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           en_q <= EN_RST;
        else if (cpu_wr && cpu_addr == A_EN)  en_q <= cpu_wdata;
    end

    assign pend_v = raw_v & en_q;
    assign irq    = |pend_v;

    always_comb begin
        case (cpu_addr)
            A_PEND:   rd_val = 32'(pend_v);
            A_EN:     rd_val = 32'(en_q);
            A_RAW:    rd_val = 32'(raw_v);
            A_RXTHR:  rd_val = 32'(rx_thr);
            A_TXTHR:  rd_val = 32'(tx_thr);
            A_STAT:   rd_val = 32'({eng_ctrl_active, rx_full, !rx_empty,
                                    tx_empty, !tx_full, eng_bus_busy});
            A_TXLVL:  rd_val = 32'(tx_lvl);
            A_RXLVL:  rd_val = 32'(rx_lvl);
            A_CAUSE:  rd_val = 32'(cause_q);
            A_CLRALL: rd_val = 32'(|sticky_v | hold);
            A_CLRRXU: rd_val = 32'(sticky_v[B_RXUND]);
            A_CLRRXO: rd_val = 32'(sticky_v[B_RXOVR]);
            A_CLRTXO: rd_val = 32'(sticky_v[B_TXOVR]);
            A_CLRTXA: rd_val = 32'(hold);
            A_CLRACT: rd_val = 32'(sticky_v[B_ACT]);
            A_CLRSTP: rd_val = 32'(sticky_v[B_STOP]);
            A_CLRSTA: rd_val = 32'(sticky_v[B_START]);
            A_CLRGC:  rd_val = 32'(sticky_v[B_GCALL]);
            default:  rd_val = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= 32'd0;
        else if (rd_at)  rdata_q <= rd_val;
        else             rdata_q <= 32'd0;
    end

    assign cpu_rdata = rdata_q;
    assign tx_flush  = hold;
endmodule

// File: rtl/i2cs_unit_sva.sv
module i2cs_unit_sva
    import i2cs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_rd,
    input logic [7:0]       cpu_addr,
    input logic             eng_abort,
    input logic             eng_bus_busy,
    input logic             tx_flush,
    input logic [IRQ_W-1:0] raw_v,
    input logic [LVL_W-1:0] tx_lvl,
    input logic [LVL_W-1:0] rx_lvl
);
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> (tx_lvl == '0)); // R10

    AST_FLUSH_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flush) |-> $past(eng_abort)); // R10

    AST_FLUSH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !(cpu_rd && (cpu_addr == A_CLRTXA || cpu_addr == A_CLRALL)))
        |=> tx_flush); // R10

    AST_TXOVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_v[B_TXOVR] && !(cpu_rd && (cpu_addr == A_CLRTXO || cpu_addr == A_CLRALL)))
        |=> raw_v[B_TXOVR]); // R7

    AST_ACT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_v[B_ACT] && eng_bus_busy) |=> raw_v[B_ACT]); // R12

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl <= LVL_W'(DEPTH)) && (rx_lvl <= LVL_W'(DEPTH))); // R8

    AST_UNDER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == A_QUEUE && rx_lvl == '0) |=> raw_v[B_RXUND]); // R8
endmodule

bind i2cs_unit i2cs_unit_sva #(.DEPTH(DEPTH)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_rd      (cpu_rd),
    .cpu_addr    (cpu_addr),
    .eng_abort   (eng_abort),
    .eng_bus_busy(eng_bus_busy),
    .tx_flush    (tx_flush),
    .raw_v       (raw_v),
    .tx_lvl      (tx_lvl),
    .rx_lvl      (rx_lvl)
);

// File: tb/i2cs_unit_tb_top.sv
`timescale 1ns/1ps
module i2cs_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 0, cpu_rd = 0;
    logic [7:0]  cpu_addr = 0;
    logic [11:0] cpu_wdata = 0;
    logic [31:0] cpu_rdata;
    logic        eng_start = 0, eng_stop = 0, eng_activity = 0, eng_gen_call = 0;
    logic        eng_abort = 0;
    logic [16:0] eng_abort_cause = 0;
    logic        eng_tx_pop = 0, eng_rx_push = 0, eng_ctrl_active = 0, eng_bus_busy = 0;
    logic        irq, tx_flush;

    always #2.5 clk = ~clk;

    i2cs_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .eng_start(eng_start), .eng_stop(eng_stop), .eng_activity(eng_activity),
        .eng_gen_call(eng_gen_call), .eng_abort(eng_abort),
        .eng_abort_cause(eng_abort_cause), .eng_tx_pop(eng_tx_pop),
        .eng_rx_push(eng_rx_push), .eng_ctrl_active(eng_ctrl_active),
        .eng_bus_busy(eng_bus_busy), .irq(irq), .tx_flush(tx_flush)
    );

    int    n_vec = 0, n_bad = 0;
    bit    finished = 0;
    string cur_tag = "R14";

    // ---------------- behavioural reference model ----------------
    int          m_txl, m_rxl, m_ttx, m_trx, t0, r0;
    logic [11:0] m_en, m_st;
    bit          m_hold, ab, rel, call, tover, rover, runder, pushq, popq;
    logic [16:0] m_src;
    logic [31:0] m_rdata;

    function automatic logic [11:0] m_raw();
        logic [11:0] r;
        r    = m_st & 12'hF0B;
        r[6] = m_hold;
        r[4] = (m_txl <= m_ttx);
        r[2] = (m_rxl >= m_trx);
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h04: return 32'(m_raw() & m_en);
            8'h08: return 32'(m_en);
            8'h0C: return 32'(m_raw());
            8'h10: return 32'(m_trx);
            8'h14: return 32'(m_ttx);
            8'h18: return {26'd0, eng_ctrl_active, m_rxl == 16, m_rxl != 0,
                           m_txl == 0, m_txl != 16, eng_bus_busy};
            8'h1C: return 32'(m_txl);
            8'h20: return 32'(m_rxl);
            8'h24: return 32'(m_src);
            8'h40: return 32'((|(m_st & 12'hF0B)) | m_hold);
            8'h44: return 32'(m_st[0]);
            8'h48: return 32'(m_st[1]);
            8'h4C: return 32'(m_st[3]);
            8'h50: return 32'(m_hold);
            8'h54: return 32'(m_st[8]);
            8'h58: return 32'(m_st[9]);
            8'h5C: return 32'(m_st[10]);
            8'h60: return 32'(m_st[11]);
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit upd(input bit cur, input bit set, input bit clr);
        if (set) return 1'b1;
        if (clr) return 1'b0;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txl = 0; m_rxl = 0; m_ttx = 0; m_trx = 1;
            m_en = 12'h8FF; m_st = 0; m_hold = 0; m_src = 0; m_rdata = 0;
        end else begin
            m_rdata = cpu_rd ? m_read(cpu_addr) : 32'd0;
            ab   = eng_abort;
            call = cpu_rd && cpu_addr == 8'h40;
            rel  = cpu_rd && (cpu_addr == 8'h50 || call);
            // transmit queue
            t0 = m_txl; tover = 0;
            pushq = cpu_wr && cpu_addr == 8'h00;
            if (ab || m_hold) m_txl = 0;
            else begin
                tover = pushq && t0 == 16;
                m_txl = t0 + ((pushq && t0 < 16) ? 1 : 0) - ((eng_tx_pop && t0 > 0) ? 1 : 0);
            end
            // receive queue
            r0 = m_rxl;
            popq   = cpu_rd && cpu_addr == 8'h00;
            runder = popq && r0 == 0;
            rover  = eng_rx_push && r0 == 16;
            m_rxl  = r0 + ((eng_rx_push && r0 < 16) ? 1 : 0) - ((popq && r0 > 0) ? 1 : 0);
            // abort latch and cause word
            if (rel) m_src = ab ? eng_abort_cause : 17'd0;
            else if (ab) m_src = m_src | eng_abort_cause;
            if (ab) m_hold = 1; else if (rel) m_hold = 0;
            // sticky flags
            m_st[0]  = upd(m_st[0],  runder,       call || (cpu_rd && cpu_addr == 8'h44));
            m_st[1]  = upd(m_st[1],  rover,        call || (cpu_rd && cpu_addr == 8'h48));
            m_st[3]  = upd(m_st[3],  tover,        call || (cpu_rd && cpu_addr == 8'h4C));
            m_st[8]  = upd(m_st[8],  eng_activity, (call || (cpu_rd && cpu_addr == 8'h54)) && !eng_bus_busy);
            m_st[9]  = upd(m_st[9],  eng_stop,     call || (cpu_rd && cpu_addr == 8'h58));
            m_st[10] = upd(m_st[10], eng_start,    call || (cpu_rd && cpu_addr == 8'h5C));
            m_st[11] = upd(m_st[11], eng_gen_call, call || (cpu_rd && cpu_addr == 8'h60));
            // writable words
            if (cpu_wr && cpu_addr == 8'h08) m_en = cpu_wdata;
            if (cpu_wr && cpu_addr == 8'h10) m_trx = (cpu_wdata[7:0] > 16) ? 16 : int'(cpu_wdata[7:0]);
            if (cpu_wr && cpu_addr == 8'h14) m_ttx = (cpu_wdata[7:0] > 16) ? 16 : int'(cpu_wdata[7:0]);
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic go();
        @(posedge clk);
        @(negedge clk);
        chk("R3 irq",       32'(irq),      32'(|(m_raw() & m_en)));
        chk("R10 tx_flush", 32'(tx_flush), 32'(m_hold));
        chk(cur_tag,        cpu_rdata,     m_rdata);
        cur_tag = "R14";
        cpu_wr = 0; cpu_rd = 0;
        eng_start = 0; eng_stop = 0; eng_activity = 0; eng_gen_call = 0;
        eng_abort = 0; eng_abort_cause = 0; eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [11:0] d);
        cpu_wr = 1; cpu_addr = a; cpu_wdata = d; go();
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cpu_rd = 1; cpu_addr = a; cur_tag = tag; go();
    endtask

    task automatic rdx(input logic [7:0] a, input string tag, input logic [31:0] exp);
        rd(a, tag);
        chk(tag, cpu_rdata, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [7:0] addr_list [19] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                  8'h1C, 8'h20, 8'h24, 8'h40, 8'h44, 8'h48, 8'h4C,
                                  8'h50, 8'h54, 8'h58, 8'h5C, 8'h60};

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 rdata in reset", cpu_rdata, 32'd0);
        rst_n = 1;
        @(negedge clk);
        // R1 / R2 / R13: reset values
        rdx(8'h08, "R1 enable", 32'h8FF);
        rdx(8'h18, "R13 status", 32'h06);
        rdx(8'h14, "R1 tx thr", 32'd0);
        rdx(8'h10, "R1 rx thr", 32'd1);
        rdx(8'h0C, "R2 raw", 32'h010);
        chk("R3 irq at reset", 32'(irq), 32'd1);
        go();
        chk("R14 idle rdata", cpu_rdata, 32'd0);
        // R3: enable controls irq
        wr(8'h08, 12'h000);
        chk("R3 masked off", 32'(irq), 32'd0);
        rdx(8'h04, "R3 pend", 32'd0);
        wr(8'h08, 12'hFFF);
        // R4: TX threshold flag
        wr(8'h14, 12'd3);
        for (int i = 0; i < 4; i++) wr(8'h00, 12'd0);
        rdx(8'h0C, "R4 above thr", 32'h000);
        eng_tx_pop = 1; go();
        rdx(8'h0C, "R4 back at thr", 32'h010);
        // R7: overflow of TX queue
        for (int i = 0; i < 13; i++) wr(8'h00, 12'd0);
        rdx(8'h1C, "R7 tx level full", 32'd16);
        wr(8'h00, 12'd0);
        rdx(8'h1C, "R7 level held", 32'd16);
        rdx(8'h18, "R13 tx full status", 32'h00);
        eng_tx_pop = 1; cpu_wr = 1; cpu_addr = 8'h00; go(); // R7 full-start push lost
        rdx(8'h4C, "R9 clear returns set", 32'd1);
        rdx(8'h4C, "R9 clear returns clear", 32'd0);
        // R6: clamp
        wr(8'h14, 12'h020);
        rdx(8'h14, "R6 clamp", 32'd16);
        rd(8'h0C, "R4 thr 16");
        wr(8'h14, 12'd16);
        rdx(8'h14, "R6 exact 16", 32'd16);
        // R5 / R8: RX side
        wr(8'h10, 12'd2);
        eng_rx_push = 1; go();
        rd(8'h0C, "R5 below");
        eng_rx_push = 1; go();
        rd(8'h0C, "R5 at thr");
        rd(8'h00, "R8 pop");
        rd(8'h0C, "R5 dropped");
        rd(8'h00, "R8 pop last");
        rd(8'h00, "R8 under");
        rdx(8'h44, "R8 under flag", 32'd1);
        for (int i = 0; i < 17; i++) begin eng_rx_push = 1; go(); end
        rdx(8'h20, "R8 rx level", 32'd16);
        rdx(8'h48, "R8 over flag", 32'd1);
        rd(8'h18, "R13 rx full status");
        // R9: events and set beating clear
        eng_start = 1; eng_stop = 1; eng_gen_call = 1; go();
        rd(8'h0C, "R2 event bits");
        eng_start = 1; cpu_rd = 1; cpu_addr = 8'h5C; cur_tag = "R9 set vs clr"; go();
        rdx(8'h5C, "R9 set wins", 32'd1);
        rd(8'h58, "R9 clr stop");
        rd(8'h60, "R9 clr gcall");
        // R12: activity clear while busy
        eng_bus_busy = 1; eng_activity = 1; go();
        rd(8'h54, "R12 busy clr");
        rdx(8'h54, "R12 still set", 32'd1);
        eng_bus_busy = 0; go();
        rd(8'h54, "R12 clr idle");
        rdx(8'h54, "R12 cleared", 32'd0);
        // R10: abort handling
        eng_abort = 1; eng_abort_cause = 17'h00010; go();
        chk("R10 flush on", 32'(tx_flush), 32'd1);
        wr(8'h00, 12'd0);
        rdx(8'h1C, "R10 writes dropped", 32'd0);
        rdx(8'h0C, "R10 no txover", 32'(m_raw()));
        eng_abort = 1; eng_abort_cause = 17'h01000; go();
        rdx(8'h24, "R10 cause accum", 32'h01010);
        eng_abort = 1; eng_abort_cause = 17'h00001; cpu_rd = 1; cpu_addr = 8'h50;
        cur_tag = "R10 clr with abort"; go();
        chk("R10 abort wins", 32'(tx_flush), 32'd1);
        rdx(8'h24, "R10 cause reloaded", 32'h00001);
        rdx(8'h50, "R10 release", 32'd1);
        chk("R10 flush off", 32'(tx_flush), 32'd0);
        rdx(8'h24, "R10 cause cleared", 32'd0);
        // R11: global clear
        eng_abort = 1; eng_abort_cause = 17'h00004; eng_stop = 1; go();
        wr(8'h00, 12'd0);
        rdx(8'h40, "R11 returns any", 32'd1);
        rd(8'h0C, "R11 only thr flags");
        rdx(8'h24, "R11 cause", 32'd0);
        rdx(8'h40, "R11 nothing left", 32'd0);
        // mixed random phase against the model
        for (int i = 0; i < 4000; i++) begin
            cpu_addr = addr_list[$urandom_range(0, 18)];
            cpu_wdata = 12'($urandom);
            cpu_wr = ($urandom_range(0, 3) == 0);
            cpu_rd = ($urandom_range(0, 2) == 0);
            if (cpu_wr && (cpu_addr == 8'h10 || cpu_addr == 8'h14))
                cpu_wdata = 12'($urandom_range(0, 20));
            eng_start = ($urandom_range(0, 15) == 0);
            eng_stop = ($urandom_range(0, 15) == 0);
            eng_activity = ($urandom_range(0, 7) == 0);
            eng_gen_call = ($urandom_range(0, 31) == 0);
            eng_abort = ($urandom_range(0, 63) == 0);
            eng_abort_cause = 17'($urandom);
            eng_tx_pop = ($urandom_range(0, 3) == 0);
            eng_rx_push = ($urandom_range(0, 2) == 0);
            if ((i % 37) == 0) eng_bus_busy = ~eng_bus_busy;
            if ((i % 53) == 0) eng_ctrl_active = ~eng_ctrl_active;
            cur_tag = "R9 mixed";
            go();
        end
        finish_run();
    end
endmodule